// File: doc/BRIEF.md
# Synchronous FIFO with Fractional Fill and Free-Space Levels

This block is a single-clock first-in first-out buffer. A producer offers a word by raising `put` with `din`. The word is taken on that edge unless `full` is high. A consumer sees the oldest stored word on `dout` while `valid` is high. It pulses `got` to retire that word, and the next word is then presented. The consumer does not request data: the head word is always shown ahead.

Two coarse level outputs help with scheduling decisions, but they never replace `full` and `valid`:
- `fill_lvl` reports how much of the storage is guaranteed to hold data.
- `free_lvl` reports how much is guaranteed to be writable.

Each level output is a fraction of the depth with a parameter-chosen number of bits. Each is a lower bound taken straight from the pointer difference. A width of zero turns that output off.

Two options change the build:
- One option makes `full` and the internal empty flag come from flip-flops rather than from the pointer comparison.
- The other adds a prefetching output register in front of `dout`.

Top module: `frac_fifo`

## Requirements
- R1: After a synchronous active-low reset, `valid` and `full` are 0. `fill_lvl` is 0. `free_lvl` is all ones when enabled and 0 when disabled.
- R2: A `put` while `full` is 0 stores `din`. Words appear on `dout` in the order they were stored, and `dout` is meaningful only while `valid` is 1.
- R3: `full` is 1 exactly when the storage array holds DEPTH words. A `put` while `full` is 1 is ignored, even when `got` is asserted in the same cycle.
- R4: A `got` while `valid` is 1 retires the head word. A `got` while `valid` is 0 has no effect.
- R5: A `put` and a `got` in the same cycle, while the array is neither empty nor full, leave the stored count unchanged.
- R6: DEPTH is MIN_DEPTH rounded up to the next power of two, with a minimum of 2. With MIN_DEPTH = 5 the array accepts exactly 8 words before `full` rises.
- R7: Let n be the number of words in the array and F = FILL_BITS, with 1 ≤ F ≤ log2(DEPTH). Then `fill_lvl` = floor(n·2^F/DEPTH), saturated at 2^F−1.
- R8: Let E = FREE_BITS, with 1 ≤ E ≤ log2(DEPTH). Then `free_lvl` = floor((DEPTH−n)·2^E/DEPTH), saturated at 2^E−1.
- R9: A level width parameter of 0 makes the matching output a constant 0, one bit wide.
- R10: With OUT_REG = 1, the head word is moved into an output register as soon as that register is free or being retired. `valid` and `dout` then hold until `got`. A word written into an empty FIFO shows `valid` two edges after its `put`. The total capacity is DEPTH+1, and n in R7 and R8 counts only the array.
- R11: FLAG_REG changes where `full` and the empty flag are produced but not their cycle timing at the ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous reset, active low |
| put | input | 1 | Write request |
| din | input | DATA_W | Write data |
| full | output | 1 | No room for another word |
| free_lvl | output | max(1,FREE_BITS) | Guaranteed free fraction |
| got | input | 1 | Consumer has taken the head word |
| dout | output | DATA_W | Head word |
| valid | output | 1 | `dout` holds a word |
| fill_lvl | output | max(1,FILL_BITS) | Guaranteed filled fraction |

## Verification
The bench fills the buffer past its capacity and drains it past empty.
- A design that lets the write pointer wrap on a put while full would overwrite the oldest word, and the data order would break.
- A design that honours `got` while empty would drift its read pointer and later present stale data.

Long runs of simultaneous put and got at partial occupancy catch a count that moves on concurrent operations. The level outputs are compared at every occupancy, including the saturating full and empty ends, where a missing clamp would wrap to zero. A second build with the output register checks two things:
- the two-edge first-word latency;
- that `dout` stays frozen while `got` is low, which a register reloading every cycle would violate.

// File: rtl/frac_fifo_pkg.sv
// Package frac_fifo_pkg
// Purpose : shared sizing helpers for the fractional-level FIFO.
// Assumes : arguments are elaboration-time constants.
package frac_fifo_pkg;

    // Round a requested depth up to a power of two, never below 2.
    function automatic int pow2_depth(input int min_depth);
        int d;
        d = 2;
        while (d < min_depth) d = d * 2;
        return d;
    endfunction

    // Port width of a level output: a disabled output still needs one bit.
    function automatic int level_width(input int bits);
        return (bits < 1) ? 1 : bits;
    endfunction

endpackage

// File: rtl/frac_fifo_ptrs.sv
// Module frac_fifo_ptrs
// Purpose : read/write pointers one bit wider than the address, plus the
//           full/empty flags and the stored-word count.
// Assumes : push_req/pop_req are raw requests; gating against full/empty
//           is done here. FLAG_REG selects registered flags computed from
//           next-state pointers, so timing at the ports is unchanged.
module frac_fifo_ptrs #(
    parameter int ADDR_W   = 3,
    parameter bit FLAG_REG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    output logic              push_ok,
    output logic              pop_ok,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   used,
    output logic              full,
    output logic              empty
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] FULL_XOR = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [PW-1:0] DEPTH_V  = FULL_XOR;

    logic [PW-1:0] wptr_q, rptr_q, wptr_d, rptr_d;
    logic          full_c, empty_c;

    assign full_c  = ((wptr_q ^ rptr_q) == FULL_XOR);
    assign empty_c = (wptr_q == rptr_q);

    assign push_ok = push_req & ~full;
    assign pop_ok  = pop_req & ~empty;

    // Next-state pointers.
    always_comb begin
        wptr_d = wptr_q + PW'(push_ok);
        rptr_d = rptr_q + PW'(pop_ok);
    end

    // Pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            wptr_q <= wptr_d;
            rptr_q <= rptr_d;
        end
    end

    generate
        if (FLAG_REG) begin : g_flag_reg
            logic full_q, empty_q;
            // Flags registered from the next-state pointers.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    full_q  <= 1'b0;
                    empty_q <= 1'b1;
                end else begin
                    full_q  <= ((wptr_d ^ rptr_d) == FULL_XOR);
                    empty_q <= (wptr_d == rptr_d);
                end
            end
            assign full  = full_q;
            assign empty = empty_q;
        end else begin : g_flag_comb
            assign full  = full_c;
            assign empty = empty_c;
        end
    endgenerate

    assign wr_addr = wptr_q[ADDR_W-1:0];
    assign rd_addr = rptr_q[ADDR_W-1:0];
    assign used    = wptr_q - rptr_q;

    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (full == (used == DEPTH_V)) && (empty == (used == '0)));            // R11
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop_req |=> full && $stable(wr_addr));                     // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop_req |=> $stable(rd_addr));                              // R4
    AST_SIMUL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok && pop_ok |=> used == $past(used));                          // R5

endmodule

// File: rtl/frac_fifo_store.sv
// Module frac_fifo_store
// Purpose : word storage with one write port and an asynchronous read port.
// Assumes : writes are already gated against full; contents need no reset.
module frac_fifo_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/frac_fifo_level.sv
// Module frac_fifo_level
// Purpose : quantize a word count (or its complement) into a coarse
//           fraction of the depth that never overstates the true amount.
// Assumes : BITS <= ADDR_W; BITS == 0 disables the output (constant 0).
module frac_fifo_level #(
    parameter int ADDR_W = 3,
    parameter int BITS   = 2,
    parameter bit INVERT = 1'b0,
    localparam int LW    = frac_fifo_pkg::level_width(BITS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ADDR_W:0] used,
    output logic [LW-1:0]   code
);
    localparam logic [ADDR_W:0] DEPTH_V = {1'b1, {ADDR_W{1'b0}}};

    logic [ADDR_W:0] amt;

    // Amount being measured: stored words, or free slots.
    always_comb begin
        amt = INVERT ? (DEPTH_V - used) : used;
    end

    generate
        if (BITS == 0) begin : g_off
            logic unused_amt;
            assign unused_amt = ^{amt, clk, rst_n};
            assign code = '0;
        end else begin : g_on
            // Top BITS of the address-width count, saturated at the full end.
            always_comb begin
                if (amt[ADDR_W]) code = '1;
                else             code = amt[ADDR_W-1 -: BITS];
            end

            AST_LEVEL_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
                int'(code) * int'(DEPTH_V) <= int'(amt) * (1 << BITS));      // R7
        end
    endgenerate

endmodule

// File: rtl/frac_fifo_outstage.sv
// Module frac_fifo_outstage
// Purpose : read-side presentation. Either passes the array head through
//           or prefetches it into an output register held until got.
// Assumes : core_valid is high whenever the array holds a word.
module frac_fifo_outstage #(
    parameter int DATA_W  = 8,
    parameter bit OUT_REG = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_valid,
    input  logic [DATA_W-1:0] core_data,
    input  logic              got,
    output logic              pop_core,
    output logic              valid,
    output logic [DATA_W-1:0] dout
);
    generate
        if (OUT_REG) begin : g_reg
            logic              vq;
            logic [DATA_W-1:0] dq;
            logic              take;

            assign take     = core_valid & (~vq | got);
            assign pop_core = take;

            // Output register: load when free or being retired.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vq <= 1'b0;
                end else if (take) begin
                    vq <= 1'b1;
                end else if (got) begin
                    vq <= 1'b0;
                end
            end

            // Output data: captured on each load.
            always_ff @(posedge clk) begin
                if (take) dq <= core_data;
            end

            assign valid = vq;
            assign dout  = dq;
        end else begin : g_pass
            assign pop_core = got;
            assign valid    = core_valid;
            assign dout     = core_data;
        end
    endgenerate

    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !got |=> valid && $stable(dout));                           // R10

endmodule

// File: rtl/frac_fifo.sv
// Module frac_fifo
// Purpose : single-clock FIFO, push side with put/full, show-ahead pop side
//           with valid/got, plus conservative fill and free fractions.
// Assumes : MIN_DEPTH >= 1; level widths no larger than log2 of the depth.
module frac_fifo #(
    parameter int DATA_W    = 32,
    parameter int MIN_DEPTH = 16,
    parameter bit FLAG_REG  = 1'b0,
    parameter bit OUT_REG   = 1'b0,
    parameter int FREE_BITS = 2,
    parameter int FILL_BITS = 2,
    localparam int FREE_W   = frac_fifo_pkg::level_width(FREE_BITS),
    localparam int FILL_W   = frac_fifo_pkg::level_width(FILL_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              put,
    input  logic [DATA_W-1:0] din,
    output logic              full,
    output logic [FREE_W-1:0] free_lvl,
    input  logic              got,
    output logic [DATA_W-1:0] dout,
    output logic              valid,
    output logic [FILL_W-1:0] fill_lvl
);
    localparam int DEPTH  = frac_fifo_pkg::pow2_depth(MIN_DEPTH);
    localparam int ADDR_W = $clog2(DEPTH);

    logic              push_ok, pop_ok, pop_req, empty;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [ADDR_W:0]   used;
    logic [DATA_W-1:0] head;

    frac_fifo_ptrs #(.ADDR_W(ADDR_W), .FLAG_REG(FLAG_REG)) u_ptrs (
        .clk(clk), .rst_n(rst_n),
        .push_req(put), .pop_req(pop_req),
        .push_ok(push_ok), .pop_ok(pop_ok),
        .wr_addr(wr_addr), .rd_addr(rd_addr),
        .used(used), .full(full), .empty(empty)
    );

    frac_fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .we(push_ok), .waddr(wr_addr), .wdata(din),
        .raddr(rd_addr), .rdata(head)
    );

    frac_fifo_outstage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
        .clk(clk), .rst_n(rst_n),
        .core_valid(~empty), .core_data(head), .got(got),
        .pop_core(pop_req), .valid(valid), .dout(dout)
    );

    frac_fifo_level #(.ADDR_W(ADDR_W), .BITS(FILL_BITS), .INVERT(1'b0)) u_fill (
        .clk(clk), .rst_n(rst_n), .used(used), .code(fill_lvl)
    );

    frac_fifo_level #(.ADDR_W(ADDR_W), .BITS(FREE_BITS), .INVERT(1'b1)) u_free (
        .clk(clk), .rst_n(rst_n), .used(used), .code(free_lvl)
    );

    AST_FULL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop_ok |=> full);                                           // R3
    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ok |-> $past(1'b1) && !empty);                                   // R4
    AST_PUT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok && !pop_ok |=> used == $past(used) + 1'b1);                  // R2

endmodule

// File: tb/frac_fifo_bench.sv
// Bench for frac_fifo: two builds compared each cycle with queue models.
//   A: depth 8 from MIN_DEPTH 5, registered flags, 2-bit levels.
//   B: depth 8, output register, fill level off, 3-bit free level.
module frac_fifo_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic put = 1'b0;
    logic got = 1'b0;
    logic [DW-1:0] din = '0;

    logic          full_a, valid_a, full_b, valid_b;
    logic [DW-1:0] dout_a, dout_b;
    logic [1:0]    free_a, fill_a;
    logic [2:0]    free_b;
    logic          fill_b;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    frac_fifo #(.DATA_W(DW), .MIN_DEPTH(5), .FLAG_REG(1'b1), .OUT_REG(1'b0),
                .FREE_BITS(2), .FILL_BITS(2)) u_frac_fifo (
        .clk(clk), .rst_n(rst_n), .put(put), .din(din), .full(full_a),
        .free_lvl(free_a), .got(got), .dout(dout_a), .valid(valid_a),
        .fill_lvl(fill_a)
    );

    frac_fifo #(.DATA_W(DW), .MIN_DEPTH(5), .FLAG_REG(1'b0), .OUT_REG(1'b1),
                .FREE_BITS(3), .FILL_BITS(0)) u_frac_fifo_reg (
        .clk(clk), .rst_n(rst_n), .put(put), .din(din), .full(full_b),
        .free_lvl(free_b), .got(got), .dout(dout_b), .valid(valid_b),
        .fill_lvl(fill_b)
    );

    // Reference models.
    logic [DW-1:0] qa[$];
    logic [DW-1:0] qb[$];
    bit            sv = 1'b0;
    logic [DW-1:0] sd = '0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int sat(input int v, input int mx);
        return (v > mx) ? mx : v;
    endfunction

    // Model update on each edge, from the inputs held since the falling edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            qa.delete();
            qb.delete();
            sv = 1'b0;
        end else begin
            bit pa, ua, ub, cons, load;
            pa = got && qa.size() > 0;
            ua = put && qa.size() < 8;
            if (pa) void'(qa.pop_front());
            if (ua) qa.push_back(din);
            ub   = put && qb.size() < 8;
            cons = sv && got;
            load = qb.size() > 0 && (!sv || cons);
            if (load) begin
                sd = qb.pop_front();
                sv = 1'b1;
            end else if (cons) begin
                sv = 1'b0;
            end
            if (ub) qb.push_back(din);
        end
    end

    // Per-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int na, nb;
            na = qa.size();
            nb = qb.size();
            check(valid_a == (na > 0), "R2/R4", "A valid", valid_a, na > 0);
            if (na > 0) check(dout_a == qa[0], "R2", "A dout", dout_a, qa[0]);
            check(full_a == (na == 8), "R3/R11", "A full", full_a, na == 8);
            check(fill_a == sat(na / 2, 3), "R7", "A fill_lvl", fill_a, sat(na / 2, 3));
            check(free_a == sat((8 - na) / 2, 3), "R8", "A free_lvl", free_a, sat((8 - na) / 2, 3));
            check(valid_b == sv, "R10", "B valid", valid_b, sv);
            if (sv) check(dout_b == sd, "R10", "B dout", dout_b, sd);
            check(full_b == (nb == 8), "R3", "B full", full_b, nb == 8);
            check(free_b == sat(8 - nb, 7), "R8", "B free_lvl", free_b, sat(8 - nb, 7));
            check(fill_b == 1'b0, "R9", "B fill_lvl off", fill_b, 0);
        end
    end

    task automatic step(input bit p, input bit g);
        @(negedge clk);
        put = p;
        got = g;
        din = DW'($urandom);
    endtask

    task automatic reset_checks();
        // R1: state right after reset, while reset is still held.
        check(valid_a == 1'b0, "R1", "A valid", valid_a, 0);
        check(full_a == 1'b0, "R1", "A full", full_a, 0);
        check(fill_a == 2'd0, "R1", "A fill_lvl", fill_a, 0);
        check(free_a == 2'd3, "R1", "A free_lvl", free_a, 3);
        check(valid_b == 1'b0, "R1", "B valid", valid_b, 0);
        check(free_b == 3'd7, "R1", "B free_lvl", free_b, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        reset_checks();
        rst_n = 1'b1;

        // Fill past capacity: overflow puts must be dropped (R3, R6).
        for (int i = 0; i < 7; i++) step(1'b1, 1'b0);
        @(negedge clk);
        check(full_a == 1'b0, "R6", "A full after 7 puts", full_a, 0);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        @(negedge clk);
        check(full_a == 1'b1, "R6", "A full after capacity", full_a, 1);
        // Put with got while full: put must be ignored (R3).
        step(1'b1, 1'b1);
        step(1'b0, 1'b0);

        // Drain past empty: extra got must do nothing (R4).
        for (int i = 0; i < 14; i++) step(1'b0, 1'b1);
        step(1'b0, 1'b0);

        // First-word latency of the registered build (R10).
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        check(valid_b == 1'b0, "R10", "B valid one edge after put", valid_b, 0);
        @(negedge clk);
        check(valid_b == 1'b1, "R10", "B valid two edges after put", valid_b, 1);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        // Steady put+got at partial occupancy (R5).
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1);
        step(1'b0, 1'b0);

        // Random traffic with varied bias.
        for (int i = 0; i < 600; i++)
            step(($urandom % 10) < 6, ($urandom % 10) < 4);
        for (int i = 0; i < 600; i++)
            step(($urandom % 10) < 4, ($urandom % 10) < 7);
        for (int i = 0; i < 600; i++)
            step($urandom % 2, $urandom % 2);

        // Mid-run reset (R1).
        @(negedge clk);
        put = 1'b0;
        got = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        reset_checks();
        rst_n = 1'b1;
        for (int i = 0; i < 200; i++)
            step(($urandom % 10) < 7, ($urandom % 10) < 3);
        step(1'b0, 1'b0);
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule